// File: doc/BRIEF.md
# Successive-Approximation ADC Conversion Controller with Result Compare

This block is the digital sequencer that sits around a 12-bit successive-approximation converter. Software enables the block, sets a go bit, and the controller spends one sample slot followed by twelve bit-decision slots. In each slot it drives a trial code to an external DAC and reads back one comparator bit. When the last bit is decided, the controller stores the code, drops go, raises a sticky interrupt flag and refreshes a compare flag. The compare flag holds the outcome of comparing the new result against a software-loaded preset, and a polarity bit selects the sense of that comparison.

Slot pacing comes from a programmable clock divider, so a conversion always takes a fixed number of system clocks. Software can abort a conversion at any time by clearing go or enable. An aborted conversion never touches the stored result, the compare flag or the interrupt flag.

Registers sit on a byte-wide write port with a combinational read port. Address 0 is control/status; 1 is the divider; 2 and 3 are the result high/low bytes; 4 and 5 are the preset high/low bytes. Any other address reads 0.

Top module: `sar_adc_ctrl`

## Requirements
- R1: A control write (address 0) starts a conversion only if the stored enable bit (bit 0) is already 1 and the written data has bit 0 = 1 and bit 1 (go) = 1. Otherwise go reads back 0 after a write of go = 1.
- R2: Once a conversion starts, go clears by itself exactly 13 × (DIV + 1) clock edges after the starting write edge, where DIV is the divider register value (address 1).
- R3: Completing a conversion sets the interrupt flag (control bit 4). The flag stays set when a new conversion starts and when a control write has bit 4 = 1. It clears only on a control write with bit 4 = 0.
- R4: For each trial, the controller sets the next lower bit. It keeps that bit when cmp_in = 1 and drops it when cmp_in = 0, starting from bit 11. With a comparator that reports input ≥ dac_code, the stored result equals the input code.
- R5: The result is right-justified. Address 2 reads bits 11:8 in its low nibble with the upper nibble 0. Address 3 reads bits 7:0.
- R6: With polarity (control bit 2) = 0, the compare flag (control bit 3, read-only) is set at completion to 1 when result ≥ preset. The preset is {address 4 bits 3:0, address 5}.
- R7: With polarity = 1, the compare flag is set at completion to 1 when result < preset.
- R8: The compare flag changes only when a conversion completes. Later writes to polarity or to the preset leave it unchanged.
- R9: An abort keeps the previous result, the compare flag and the interrupt flag. An abort is a control write while busy with bit 0 or bit 1 equal to 0.
- R10: After reset, every register reads 0, dac_code is 0 and irq is 0. While idle, dac_code is 0. One slot after a start with DIV = 0, dac_code presents 0x800.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for write and read |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Read data for `addr` (combinational) |
| dac_code | output | 12 | Trial code driven to the external DAC |
| cmp_in | input | 1 | Analog comparator output: 1 means input ≥ trial |
| irq | output | 1 | Interrupt flag level |

## Verification
The hardest situation to reach from the ports is an abort landing partway through the bit-decision sequence after an earlier conversion has completed. Only in that case can a discarded partial code overwrite a valid result. The bench first completes a conversion of a known input. It then starts a conversion of a very different input, waits a fixed number of cycles into the bit slots, and aborts by clearing go and separately by clearing enable. It checks that the result, the compare flag and the interrupt flag are the old values. A full sweep of all 4096 input codes, with varying preset and alternating polarity, covers the decision logic and both compare senses.

// File: rtl/sar_adc_ctrl.sv
module sar_adc_ctrl #(
  parameter int RES_W = 12,
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [2:0]       addr,
  input  logic [7:0]       wdata,
  output logic [7:0]       rdata,
  output logic [RES_W-1:0] dac_code,
  input  logic             cmp_in,
  output logic             irq
);
  localparam int HI_W = RES_W - 8;
  localparam logic [RES_W-1:0] TOP_BIT = {1'b1, {(RES_W-1){1'b0}}};

  logic             en_q, go_q, pol_q, cmpf_q, irq_q, smp_q;
  logic [DIV_W-1:0] div_q, divc_q;
  logic [RES_W-1:0] sar_q, msk_q, res_q, pre_q;

  wire ctrl_wr = wr_en && (addr == 3'd0);
  wire start   = ctrl_wr && wdata[0] && wdata[1] && en_q && !go_q;
  wire abort   = ctrl_wr && go_q && !(wdata[0] && wdata[1]);
  wire tick    = go_q && (divc_q == div_q);
  wire [RES_W-1:0] nxt = sar_q | (cmp_in ? msk_q : '0);
  wire done    = tick && smp_q && msk_q[0] && !abort;

  wire [15:0] res16 = 16'(res_q);
  wire [15:0] pre16 = 16'(pre_q);

  assign dac_code = go_q ? (sar_q | msk_q) : '0;
  assign irq      = irq_q;

  always_comb begin
    case (addr)
      3'd0:    rdata = {3'b000, irq_q, cmpf_q, pol_q, go_q, en_q};
      3'd1:    rdata = 8'(div_q);
      3'd2:    rdata = res16[15:8];
      3'd3:    rdata = res16[7:0];
      3'd4:    rdata = pre16[15:8];
      3'd5:    rdata = pre16[7:0];
      default: rdata = 8'h00;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0; go_q <= 1'b0; pol_q <= 1'b0; cmpf_q <= 1'b0;
      irq_q <= 1'b0; smp_q <= 1'b0;
      div_q <= '0; divc_q <= '0;
      sar_q <= '0; msk_q <= '0; res_q <= '0; pre_q <= '0;
    end else begin
      if (ctrl_wr) begin
        en_q  <= wdata[0];
        pol_q <= wdata[2];
        if (!wdata[4]) irq_q <= 1'b0;
      end
      if (wr_en && addr == 3'd1) div_q <= DIV_W'(wdata);
      if (wr_en && addr == 3'd4) pre_q[RES_W-1:8] <= wdata[HI_W-1:0];
      if (wr_en && addr == 3'd5) pre_q[7:0] <= wdata;

      if (start) begin
        go_q <= 1'b1; smp_q <= 1'b0; divc_q <= '0;
        sar_q <= '0; msk_q <= '0;
      end else if (abort) begin
        go_q <= 1'b0; smp_q <= 1'b0; sar_q <= '0; msk_q <= '0;
      end else if (go_q) begin
        divc_q <= tick ? '0 : divc_q + 1'b1;
        if (tick) begin
          if (!smp_q) begin
            smp_q <= 1'b1;
            msk_q <= TOP_BIT;
          end else begin
            sar_q <= nxt;
            msk_q <= msk_q >> 1;
            if (msk_q[0]) begin
              go_q   <= 1'b0;
              smp_q  <= 1'b0;
              sar_q  <= '0;
              res_q  <= nxt;
              irq_q  <= 1'b1;
              cmpf_q <= pol_q ? (nxt < pre_q) : (nxt >= pre_q);
            end
          end
        end
      end
    end
  end

  AST_GO_NEEDS_EN: assert property (@(posedge clk) disable iff (!rst_n)
    go_q |-> en_q); // R1
  AST_DONE_FLAGS: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> (irq_q && !go_q)); // R3
  AST_IRQ_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_q && !(ctrl_wr && !wdata[4])) |=> irq_q); // R3
  AST_RES_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(res_q)); // R9
  AST_CMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !done |=> $stable(cmpf_q)); // R8
  AST_TRIAL_ONEHOT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(msk_q)); // R4
endmodule

// File: tb/sar_adc_ctrl_tb.sv
`timescale 1ns/1ps
module sar_adc_ctrl_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0;
  logic [2:0]  addr = 3'd0;
  logic [7:0]  wdata = 8'h00;
  logic [7:0]  rdata;
  logic [11:0] dac_code;
  logic        irq;
  logic [11:0] vin = 12'd0;
  wire         cmp_in = (vin >= dac_code);

  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  always #2.5 clk = ~clk;

  sar_adc_ctrl u_dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .addr(addr), .wdata(wdata),
    .rdata(rdata), .dac_code(dac_code), .cmp_in(cmp_in), .irq(irq)
  );

  task automatic chk(input int act, input int exp, input string req);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    wr_en = 1'b1; addr = a; wdata = d;
    @(posedge clk);
    #1 wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    addr = a;
    #0.5 d = rdata;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  endtask

  // start a conversion (enable already set) and count edges until go drops
  task automatic convert(input logic pol, output int cycles);
    logic [7:0] c;
    wr(3'd0, {3'b000, 1'b1, 1'b0, pol, 1'b1, 1'b1});
    addr = 3'd0;
    cycles = 0;
    do begin
      @(posedge clk);
      cycles++;
      #1 c = rdata;
    end while (c[1] && cycles < 5000);
  endtask

  function automatic int result_of(input logic [7:0] h, input logic [7:0] l);
    return {h, l};
  endfunction

  initial begin
    #(200000 * 5);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=timeout expected=finish");
    finish_run();
  end

  initial begin
    logic [7:0] c, h, l;
    int cyc;
    int pre;
    int expf;
    #12 rst_n = 1'b1;

    for (int a = 0; a < 8; a++) begin
      rd(3'(a), c);
      chk(c, 0, "R10 reset register");
    end
    chk(dac_code, 0, "R10 reset dac_code");
    chk(irq, 0, "R10 reset irq");

    wr(3'd0, 8'h03);
    rd(3'd0, c);
    chk(c[1], 0, "R1 go while disabled");
    wr(3'd0, 8'h02);
    rd(3'd0, c);
    chk(c[1], 0, "R1 go with enable written 0");
    chk(dac_code, 0, "R10 idle dac_code");

    wr(3'd1, 8'd0);
    wr(3'd0, 8'h01);
    vin = 12'hABC;
    wr(3'd0, 8'h13);
    @(posedge clk);
    #1 chk(dac_code, 12'h800, "R10 first trial code");
    addr = 3'd0;
    do begin @(posedge clk); #1 c = rdata; end while (c[1]);

    for (int v = 0; v < 4096; v++) begin
      vin = 12'(v);
      pre = (v * 37 + 100) % 4096;
      wr(3'd4, 8'(pre >> 8));
      wr(3'd5, 8'(pre));
      convert(v[0], cyc);
      chk(cyc, 13, "R2 conversion length DIV=0");
      rd(3'd2, h);
      rd(3'd3, l);
      chk(h[7:4], 0, "R5 high byte upper nibble");
      chk(result_of(h, l), v, "R4 R5 result");
      rd(3'd0, c);
      expf = v[0] ? int'(v < pre) : int'(v >= pre);
      chk(c[3], expf, v[0] ? "R7 compare pol1" : "R6 compare pol0");
      chk(c[4], 1, "R3 irq after done");
    end

    for (int d = 1; d < 8; d += 3) begin
      wr(3'd1, 8'(d));
      vin = 12'(d * 100);
      convert(1'b0, cyc);
      chk(cyc, 13 * (d + 1), "R2 conversion length");
      rd(3'd3, l);
      chk(l, (d * 100) & 255, "R4 result with divider");
    end

    wr(3'd1, 8'd0);
    wr(3'd0, 8'h01);
    chk(irq, 0, "R3 cleared by write 0");
    wr(3'd0, 8'h11);
    chk(irq, 0, "R3 write 1 does not set");
    vin = 12'd100;
    wr(3'd4, 8'h00); wr(3'd5, 8'd50);
    convert(1'b0, cyc);
    chk(irq, 1, "R3 set on completion");
    wr(3'd0, 8'h13);
    repeat (5) @(posedge clk);
    #1 chk(irq, 1, "R3 new conversion keeps irq");
    addr = 3'd0;
    do begin @(posedge clk); #1 c = rdata; end while (c[1]);
    rd(3'd0, c);
    chk(c[3], 1, "R6 flag before R8 test");
    wr(3'd0, 8'h15);
    wr(3'd5, 8'd200);
    rd(3'd0, c);
    chk(c[3], 1, "R8 polarity and preset writes no effect");

    wr(3'd0, 8'h01);
    vin = 12'd3000;
    wr(3'd0, 8'h03);
    repeat (7) @(posedge clk);
    wr(3'd0, 8'h01);
    rd(3'd0, c);
    chk(c[1], 0, "R9 abort by go=0");
    chk(c[4], 0, "R9 abort no irq");
    chk(c[3], 1, "R9 abort keeps compare flag");
    rd(3'd3, l);
    chk(l, 100, "R9 abort keeps result");
    wr(3'd0, 8'h03);
    repeat (9) @(posedge clk);
    wr(3'd0, 8'h00);
    rd(3'd0, c);
    chk(c[1], 0, "R9 abort by enable=0");
    rd(3'd3, l);
    rd(3'd2, h);
    chk(result_of(h, l), 100, "R9 enable abort keeps result");
    chk(dac_code, 0, "R10 dac_code idle after abort");

    finish_run();
  end
endmodule